// File: doc/BRIEF.md
# UART Line Status Logic

This block produces the four live bits of a UART line status byte: a receive error summary, transmitter-fully-empty, transmit-holding-empty and a received break indication. It watches the receive FIFO's push and pop traffic together with the error tags of each byte, the transmitter's three empty/idle conditions and its break-send control, and the raw receive line sampled on baud ticks. A read strobe from the register decoder clears the bits that clear on read.

The break detector times how long the receive line stays low, counted in baud ticks. When the low period exceeds one full character time for the programmed format, it raises the break indication. With the FIFO enabled, it also emits one single-cycle request to load a null byte tagged with a framing error into the receive FIFO. A count of error-tagged bytes held in the FIFO keeps the error summary from clearing while such bytes remain.

Top module: `uart_lsr_core`

## Requirements
- R1: After reset `lsr` reads 0x60 (bit 6 and bit 5 set). Bits 3..0 always read 0.
- R2: While `fifo_en` is 0, bit 7 reads 0 one cycle later and the error-byte count is emptied.
- R3: With `fifo_en` at 1, pushing a byte with any of parity, framing or break error tagged sets bit 7 on that clock edge. A clean byte does not set it.
- R4: A read clears bit 7 only when no error-tagged byte remains after the pops of that same cycle. Otherwise bit 7 stays 1.
- R5: Bit 5 equals `tx_hold_empty` and not `tx_break`, registered one cycle.
- R6: Bit 6 equals `tx_hold_empty`, `tx_shift_empty` and `tx_idle` all high, and `tx_break` low, registered one cycle.
- R7: Character time T is OVS*(1 + 5 + `char_len` + `parity_en` + 1 + `two_stop`) ticks. Bit 4 sets on the (T+1)-th consecutive baud tick sampled with `rx_line` low. Cycles without a tick do not count, and a high sample restarts the count.
- R8: A read clears bit 4. A set of bit 4 or bit 7 in the same cycle as a read wins, and the bit reads 1.
- R9: On detection with `fifo_en` at 1, `brk_push` pulses for exactly one cycle, in the same cycle bit 4 becomes 1, and the null byte counts as an error-tagged byte (bit 7 sets). With `fifo_en` at 0, no pulse occurs.
- R10: A break that continues after a read-clear neither sets bit 4 again nor pushes another null until the line has returned high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fifo_en | input | 1 | Receive FIFO mode enabled |
| rx_push | input | 1 | Byte written into receive FIFO |
| rx_push_pe | input | 1 | Pushed byte has parity error |
| rx_push_fe | input | 1 | Pushed byte has framing error |
| rx_push_brk | input | 1 | Pushed byte has break tag |
| rx_pop | input | 1 | Byte read out of receive FIFO |
| rx_pop_err | input | 1 | Popped byte carries any error tag |
| tx_hold_empty | input | 1 | Transmit holding register/FIFO empty |
| tx_shift_empty | input | 1 | Transmit shift register empty |
| tx_idle | input | 1 | Transmitter idle |
| tx_break | input | 1 | Transmitter is driving a break |
| rx_line | input | 1 | Receive serial line (idle high) |
| baud_tick | input | 1 | Oversampled baud tick |
| char_len | input | 2 | Data bits minus 5 |
| parity_en | input | 1 | Parity bit present |
| two_stop | input | 1 | Two stop bits |
| lsr_rd | input | 1 | Status register read strobe |
| lsr | output | 8 | Status byte {err, temt, thre, bi, 0000} |
| brk_push | output | 1 | Load one null byte with framing error |

## Verification
A wrong error-byte count shows up at the ports only on a later read. Bit 7 either clears while tagged bytes are still queued or sticks after the last one has left, so every sweep reads the byte after each pop. A break timer that is off by one or that restarts wrongly shows as bit 4 rising one tick early or late. The bench therefore probes the exact threshold tick for every character format. A lost "already flagged" state shows within one tick after a read, as bit 4 rising again or a second `brk_push`.

// File: rtl/uart_lsr_core.sv
module uart_lsr_core #(
  parameter int FIFO_DEPTH = 16,
  parameter int OVS        = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       fifo_en,
  input  logic       rx_push,
  input  logic       rx_push_pe,
  input  logic       rx_push_fe,
  input  logic       rx_push_brk,
  input  logic       rx_pop,
  input  logic       rx_pop_err,
  input  logic       tx_hold_empty,
  input  logic       tx_shift_empty,
  input  logic       tx_idle,
  input  logic       tx_break,
  input  logic       rx_line,
  input  logic       baud_tick,
  input  logic [1:0] char_len,
  input  logic       parity_en,
  input  logic       two_stop,
  input  logic       lsr_rd,
  output logic [7:0] lsr,
  output logic       brk_push
);
  localparam int ECW = $clog2(FIFO_DEPTH + 1);
  localparam int TW  = $clog2(12 * OVS + 2);

  logic [ECW-1:0] ecnt, ecnt_nxt;
  logic [TW-1:0]  btmr, bthr;
  logic           err_r, temt_r, thre_r, bi_r, bseen;
  logic           brk_det, inc, dec;
  logic [3:0]     nbits;

  assign nbits = 4'd7 + 4'(char_len) + 4'(parity_en) + 4'(two_stop);
  assign bthr  = TW'(nbits) * TW'(OVS);

  assign brk_det = baud_tick && !rx_line && !bseen && (btmr == bthr);

  assign inc = fifo_en && ((rx_push && (rx_push_pe || rx_push_fe || rx_push_brk)) || brk_det);
  assign dec = fifo_en && rx_pop && rx_pop_err;

  always_comb begin
    ecnt_nxt = ecnt;
    if (!fifo_en) ecnt_nxt = '0;
    else begin
      if (inc && ecnt != ECW'(FIFO_DEPTH)) ecnt_nxt = ecnt_nxt + 1'b1;
      if (dec && ecnt_nxt != '0)           ecnt_nxt = ecnt_nxt - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ecnt <= '0;
      err_r <= 1'b0;
    end else begin
      ecnt <= ecnt_nxt;
      if (!fifo_en)                       err_r <= 1'b0;
      else if (inc)                       err_r <= 1'b1;
      else if (lsr_rd && ecnt_nxt == '0)  err_r <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      thre_r <= 1'b1;
      temt_r <= 1'b1;
    end else begin
      thre_r <= tx_hold_empty && !tx_break;
      temt_r <= tx_hold_empty && tx_shift_empty && tx_idle && !tx_break;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      btmr     <= '0;
      bseen    <= 1'b0;
      bi_r     <= 1'b0;
      brk_push <= 1'b0;
    end else begin
      brk_push <= brk_det && fifo_en;
      if (rx_line) begin
        btmr  <= '0;
        bseen <= 1'b0;
      end else if (baud_tick && !bseen) begin
        if (brk_det) bseen <= 1'b1;
        else         btmr  <= btmr + 1'b1;
      end
      if (brk_det)     bi_r <= 1'b1;
      else if (lsr_rd) bi_r <= 1'b0;
    end
  end

  assign lsr = {err_r, temt_r, thre_r, bi_r, 4'b0000};
endmodule

module uart_lsr_core_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       fifo_en,
  input logic       tx_break,
  input logic       rx_line,
  input logic [7:0] lsr,
  input logic       brk_push
);
  assert_low_nibble_R1: assert property (@(posedge clk) disable iff (!rst_n)
    lsr[3:0] == 4'b0000);
  assert_err_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !fifo_en |=> !lsr[7]);
  assert_thre_brk_R5: assert property (@(posedge clk) disable iff (!rst_n)
    tx_break |=> !lsr[5]);
  assert_temt_brk_R6: assert property (@(posedge clk) disable iff (!rst_n)
    tx_break |=> !lsr[6]);
  assert_temt_thre_R6: assert property (@(posedge clk) disable iff (!rst_n)
    lsr[6] |-> lsr[5]);
  assert_bi_line_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lsr[4]) |-> !$past(rx_line));
  assert_push_bi_R9: assert property (@(posedge clk) disable iff (!rst_n)
    brk_push |-> lsr[4]);
  assert_push_fifo_R9: assert property (@(posedge clk) disable iff (!rst_n)
    brk_push |-> $past(fifo_en));
  assert_push_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    brk_push |=> !brk_push);
endmodule

bind uart_lsr_core uart_lsr_core_chk u_chk (
  .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .tx_break(tx_break),
  .rx_line(rx_line), .lsr(lsr), .brk_push(brk_push)
);

// File: tb/test_uart_lsr_core.sv
module test_uart_lsr_core;
  localparam int CLK_PERIOD = 10;
  localparam int OVS = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic fifo_en = 0, rx_push = 0, rx_push_pe = 0, rx_push_fe = 0, rx_push_brk = 0;
  logic rx_pop = 0, rx_pop_err = 0, tx_hold_empty = 1, tx_shift_empty = 1, tx_idle = 1;
  logic tx_break = 0, rx_line = 1, baud_tick = 1, parity_en = 0, two_stop = 0, lsr_rd = 0;
  logic [1:0] char_len = 0;
  logic [7:0] lsr;
  logic brk_push;
  int n_run = 0, n_fail = 0, npush = 0;

  uart_lsr_core #(.FIFO_DEPTH(8), .OVS(OVS)) i_uart_lsr_core (.*);

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) if (brk_push) npush++;

  task automatic step(); @(negedge clk); endtask

  task automatic check(string req, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic rd();
    lsr_rd = 1; step(); lsr_rd = 0;
  endtask

  initial begin
    #(CLK_PERIOD*150000);
    n_run++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    step(); step();
    check("R1 reset", lsr, 8'h60);
    rst_n = 1; step();
    check("R1 after release", lsr, 8'h60);

    for (int v = 0; v < 16; v++) begin
      {tx_hold_empty, tx_shift_empty, tx_idle, tx_break} = 4'(v);
      step();
      check("R5 thre", lsr[5], tx_hold_empty && !tx_break);
      check("R6 temt", lsr[6], tx_hold_empty && tx_shift_empty && tx_idle && !tx_break);
    end
    tx_hold_empty = 1; tx_shift_empty = 1; tx_idle = 1; tx_break = 1; step();
    check("R6 during break", lsr[6:5], 0);
    tx_break = 0; step();
    check("R5 after break removed", lsr[6:5], 3);

    fifo_en = 0; rx_push = 1; rx_push_fe = 1; step(); rx_push = 0; rx_push_fe = 0;
    check("R2 fifo off", lsr[7], 0);
    fifo_en = 1; step();
    check("R2 count emptied", lsr[7], 0);

    for (int t = 0; t < 4; t++) begin
      rx_push = 1; {rx_push_pe, rx_push_fe, rx_push_brk} = (t == 0) ? 3'b000 : 3'(1 << (t - 1));
      step(); rx_push = 0; {rx_push_pe, rx_push_fe, rx_push_brk} = 0;
      check("R3 tag set", lsr[7], t != 0);
      rx_pop = 1; rx_pop_err = (t != 0); lsr_rd = 1; step();
      rx_pop = 0; rx_pop_err = 0; lsr_rd = 0;
      check("R4 clear after last pop", lsr[7], 0);
    end

    for (int k = 1; k <= 3; k++) begin
      for (int j = 0; j < k; j++) begin
        rx_push = 1; rx_push_pe = 1; step();
      end
      rx_push = 0; rx_push_pe = 0;
      rd();
      check("R4 read with bytes queued", lsr[7], 1);
      for (int j = k; j > 0; j--) begin
        rx_pop = 1; rx_pop_err = 1; lsr_rd = 1; step();
        rx_pop = 0; rx_pop_err = 0; lsr_rd = 0;
        check("R4 pop and read", lsr[7], (j - 1) > 0);
      end
    end
    rx_push = 1; rx_push_fe = 1; lsr_rd = 1; step();
    rx_push = 0; rx_push_fe = 0; lsr_rd = 0;
    check("R8 err set beats read", lsr[7], 1);
    rx_pop = 1; rx_pop_err = 1; lsr_rd = 1; step(); rx_pop = 0; rx_pop_err = 0; lsr_rd = 0;

    for (int c = 0; c < 16; c++) begin
      int thr, p0;
      {char_len, parity_en, two_stop} = 4'(c);
      fifo_en = c[0];
      thr = OVS * (7 + int'(char_len) + int'(parity_en) + int'(two_stop));
      step();
      rx_line = 0;
      repeat (thr - 1) step();
      rx_line = 1; step(); rx_line = 0;
      repeat (thr) step();
      check("R7 restart and threshold", lsr[4], 0);
      baud_tick = 0; repeat (5) step(); baud_tick = 1;
      check("R7 no tick no count", lsr[4], 0);
      p0 = npush;
      lsr_rd = (c[1] == 1'b1); step(); lsr_rd = 0;
      check("R7 detect", lsr[4], 1);
      check("R9 push pulse", brk_push, fifo_en);
      check("R9 null counted", lsr[7], fifo_en);
      step();
      check("R9 single pulse", brk_push, 0);
      rd();
      check("R8 bi read clear", lsr[4], 0);
      repeat (thr + 3) step();
      check("R10 no reflag", lsr[4], 0);
      check("R10 one push", npush - p0, int'(fifo_en));
      rx_line = 1; step();
      rx_pop = 1; rx_pop_err = 1; lsr_rd = 1; step(); rx_pop = 0; rx_pop_err = 0; lsr_rd = 0;
      check("R4 null popped", lsr[7], 0);
      check("R1 low nibble", lsr[3:0], 0);
    end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule